// File: doc/BRIEF.md
# Multi-Retire Reorder Buffer

This block keeps the program order of instructions that an out-of-order core has in flight. At issue, each instruction takes the slot at the tail of a 16-slot ring and receives that slot's index as its tag. The slot holds the operation kind, the destination register, the PC, a result field, and flags for done and fault. Execution units report results by tag in any order. A result stays in its slot until the slot reaches the head. From the head, up to four consecutive finished slots leave per cycle, each on its own register-file write lane.

An exception is reported by completing a slot with its fault flag set. When that slot reaches the head it is not committed. The whole ring is emptied, and on the next cycle a one-cycle redirect carries the faulting instruction's PC. A misprediction is reported by completing a branch slot with its mispredict flag set. Every slot younger than the branch is dropped at once, the tail moves to just past the branch, and the next cycle carries a redirect with the corrected target. The branch itself and all older slots still retire normally.

Top module: `reorder_commit_buffer`

## Requirements
- R1: Reset behaviour. After reset the ring is empty with head and tail at 0. `alloc_ready` is 1, `alloc_tag` is 0, every `ret_valid` bit is 0 and `redirect_valid` is 0.
- R2: Allocation and tags.
  - An accepted allocation writes the slot shown on `alloc_tag`.
  - The tag then advances by one modulo 16, so it wraps from 15 to 0.
  - Tags follow program order.
- R3: Full ring.
  - The ring is full when (tail+1) mod 16 equals head, which means 15 live slots.
  - While full, `alloc_ready` is 0, a request is refused and the tail stays put.
- R4: Result hold.
  - A completed result does not appear on a write lane until its slot is among the oldest slots that may retire.
  - It then appears on `ret_data` unchanged.
- R5: Retirement width and order.
  - Lane i (0..3) carries the slot at head+i.
  - Lanes retire as an unbroken run starting at lane 0.
  - The run stops at the first slot that is empty, unfinished or faulting, and that slot and every later one wait.
  - The head advances by the number of lanes that retired.
- R6: Write lanes.
  - `ret_we[i]` is 1 only when lane i retires and the slot's kind writes a register.
  - Kind encoding: 0 = ALU, writes. 1 = branch, no write. 2 = store, no write. 3 = load, writes.
  - `ret_dest` and `ret_data` are zero on lanes that are not retiring.
- R7: Exception at the head.
  - A finished slot with its fault flag set at the head is not retired.
  - All slots are discarded and the tail is set equal to the head.
  - On the next cycle `redirect_valid`=1, `redirect_cause`=0 and `redirect_pc` equals that slot's PC.
- R8: Misprediction.
  - Completing live, unfinished slot k with `done_mispred`=1 marks k finished.
  - Every slot younger than k is discarded and the tail is set to (k+1) mod 16.
  - On the next cycle `redirect_valid`=1, `redirect_cause`=1 and `redirect_pc` equals `done_target`.
- R9: A completion to a slot that is empty or already finished is ignored.
- R10: Flush priority.
  - In a cycle where an exception flush happens, a completion is ignored.
  - In any flush cycle, an allocation is discarded.
- R11: `redirect_valid` is high for exactly the one cycle after each flush and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Request to allocate one slot |
| alloc_kind | input | 2 | Operation kind (see R6) |
| alloc_dest | input | AREG_W | Destination architectural register |
| alloc_pc | input | PC_W | PC of the instruction |
| alloc_ready | output | 1 | Ring has room for an allocation |
| alloc_tag | output | IDX_W | Slot index that the next allocation takes |
| done_valid | input | 1 | Completion report |
| done_tag | input | IDX_W | Slot being completed |
| done_value | input | DATA_W | Result value |
| done_fault | input | 1 | Instruction raised an exception |
| done_mispred | input | 1 | Branch was mispredicted |
| done_target | input | PC_W | Corrected fetch PC for a misprediction |
| ret_valid | output | RETIRE_W | Per-lane retirement this cycle |
| ret_we | output | RETIRE_W | Per-lane register-file write enable |
| ret_dest | output | RETIRE_W*AREG_W | Per-lane destination register, lane i at bits i*AREG_W |
| ret_data | output | RETIRE_W*DATA_W | Per-lane write data, lane i at bits i*DATA_W |
| redirect_valid | output | 1 | One-cycle redirect after a flush |
| redirect_cause | output | 1 | 0 = exception, 1 = misprediction |
| redirect_pc | output | PC_W | Handler PC source or corrected target |

## Verification
The bound checker enforces several properties on every cycle:
- Retirement lanes always form a run starting at lane 0.
- An empty ring retires nothing.
- A refused allocation leaves the tail where it was.
- An exception cycle commits nothing and leaves the ring empty.
- A misprediction puts the tail one past the branch.
- A redirect follows exactly the cycles that flushed.

Whether the right slots, destinations and values reach the write lanes, and whether a dropped completion or allocation really left no trace, can only be seen by comparing the bench's own ring model against the ports. That comparison covers directed fill, out-of-order, fault and mispredict scenes and a long random mix.

// File: rtl/rcb_pkg.sv
package rcb_pkg;

  typedef enum logic [1:0] {
    KIND_ALU    = 2'd0,
    KIND_BRANCH = 2'd1,
    KIND_STORE  = 2'd2,
    KIND_LOAD   = 2'd3
  } op_kind_e;

  // True when retiring an operation of this kind updates a register.
  function automatic logic kind_writes_reg(logic [1:0] kind);
    return (kind == KIND_ALU) || (kind == KIND_LOAD);
  endfunction

  // Ring index arithmetic shared by the datapath and the checker.
  function automatic int unsigned ring_add(int unsigned ptr, int unsigned step,
                                           int unsigned depth);
    return (ptr + step) % depth;
  endfunction

  // Distance of a slot from the head, 0 for the oldest slot.
  function automatic int unsigned ring_age(int unsigned idx, int unsigned head,
                                           int unsigned depth);
    return (idx + depth - head) % depth;
  endfunction

endpackage

// File: rtl/rcb_entry_store.sv
module rcb_entry_store #(
  parameter int DEPTH  = 16,
  parameter int AREG_W = 5,
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             alloc_we,
  input  logic [IDX_W-1:0]                 alloc_idx,
  input  logic [1:0]                       alloc_kind,
  input  logic [AREG_W-1:0]                alloc_dest,
  input  logic [PC_W-1:0]                  alloc_pc,
  input  logic                             cmp_we,
  input  logic [IDX_W-1:0]                 cmp_idx,
  input  logic [DATA_W-1:0]                cmp_value,
  input  logic                             cmp_fault,
  input  logic [DEPTH-1:0]                 drop_mask,
  output logic [DEPTH-1:0]                 e_valid,
  output logic [DEPTH-1:0]                 e_done,
  output logic [DEPTH-1:0]                 e_fault,
  output logic [DEPTH-1:0][1:0]            e_kind,
  output logic [DEPTH-1:0][AREG_W-1:0]     e_dest,
  output logic [DEPTH-1:0][DATA_W-1:0]     e_value,
  output logic [DEPTH-1:0][PC_W-1:0]       e_pc
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic              valid_q, done_q, fault_q;
    logic [1:0]        kind_q;
    logic [AREG_W-1:0] dest_q;
    logic [DATA_W-1:0] value_q;
    logic [PC_W-1:0]   pc_q;
    logic              hit_alloc, hit_cmp;

    assign hit_alloc = alloc_we && (alloc_idx == IDX_W'(g));
    assign hit_cmp   = cmp_we   && (cmp_idx   == IDX_W'(g));

    // Drop (retire or flush) has priority over any write into the slot.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
        done_q  <= 1'b0;
        fault_q <= 1'b0;
        kind_q  <= '0;
        dest_q  <= '0;
        value_q <= '0;
        pc_q    <= '0;
      end else if (drop_mask[g]) begin
        valid_q <= 1'b0;
        done_q  <= 1'b0;
        fault_q <= 1'b0;
      end else if (hit_alloc) begin
        valid_q <= 1'b1;
        done_q  <= 1'b0;
        fault_q <= 1'b0;
        kind_q  <= alloc_kind;
        dest_q  <= alloc_dest;
        value_q <= '0;
        pc_q    <= alloc_pc;
      end else if (hit_cmp) begin
        done_q  <= 1'b1;
        fault_q <= cmp_fault;
        value_q <= cmp_value;
      end
    end

    assign e_valid[g] = valid_q;
    assign e_done[g]  = done_q;
    assign e_fault[g] = fault_q;
    assign e_kind[g]  = kind_q;
    assign e_dest[g]  = dest_q;
    assign e_value[g] = value_q;
    assign e_pc[g]    = pc_q;
  end

endmodule

// File: rtl/rcb_retire_scan.sv
module rcb_retire_scan #(
  parameter int DEPTH    = 16,
  parameter int RETIRE_W = 4,
  parameter int IDX_W    = $clog2(DEPTH),
  parameter int CNT_W    = $clog2(RETIRE_W + 1)
) (
  input  logic [IDX_W-1:0]    head,
  input  logic [DEPTH-1:0]    e_valid,
  input  logic [DEPTH-1:0]    e_done,
  input  logic [DEPTH-1:0]    e_fault,
  output logic [RETIRE_W-1:0] take,
  output logic [CNT_W-1:0]    take_cnt,
  output logic [DEPTH-1:0]    take_mask,
  output logic                head_fault
);

  // Walk the lanes from the head; the first blocked slot ends the run.
  always_comb begin
    logic             run_ok;
    logic [IDX_W-1:0] idx;
    run_ok    = 1'b1;
    take      = '0;
    take_cnt  = '0;
    take_mask = '0;
    for (int i = 0; i < RETIRE_W; i++) begin
      idx = IDX_W'(rcb_pkg::ring_add(32'(head), 32'(i), DEPTH));
      if (run_ok && e_valid[idx] && e_done[idx] && !e_fault[idx]) begin
        take[i]        = 1'b1;
        take_mask[idx] = 1'b1;
        take_cnt       = take_cnt + CNT_W'(1);
      end else begin
        run_ok = 1'b0;
      end
    end
  end

  assign head_fault = e_valid[head] && e_done[head] && e_fault[head];

endmodule

// File: rtl/reorder_commit_buffer.sv
module reorder_commit_buffer #(
  parameter int DEPTH    = 16,
  parameter int RETIRE_W = 4,
  parameter int AREG_W   = 5,
  parameter int DATA_W   = 32,
  parameter int PC_W     = 32,
  parameter int IDX_W    = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         alloc_valid,
  input  logic [1:0]                   alloc_kind,
  input  logic [AREG_W-1:0]            alloc_dest,
  input  logic [PC_W-1:0]              alloc_pc,
  output logic                         alloc_ready,
  output logic [IDX_W-1:0]             alloc_tag,
  input  logic                         done_valid,
  input  logic [IDX_W-1:0]             done_tag,
  input  logic [DATA_W-1:0]            done_value,
  input  logic                         done_fault,
  input  logic                         done_mispred,
  input  logic [PC_W-1:0]              done_target,
  output logic [RETIRE_W-1:0]          ret_valid,
  output logic [RETIRE_W-1:0]          ret_we,
  output logic [RETIRE_W*AREG_W-1:0]   ret_dest,
  output logic [RETIRE_W*DATA_W-1:0]   ret_data,
  output logic                         redirect_valid,
  output logic                         redirect_cause,
  output logic [PC_W-1:0]              redirect_pc
);

  localparam int CNT_W = $clog2(RETIRE_W + 1);

  logic [IDX_W-1:0] head_q, tail_q, head_d, tail_d;
  logic             full, alloc_fire, alloc_commit;
  logic             cmp_hit, cmp_apply, exc_flush, mis_flush;

  logic [DEPTH-1:0]             e_valid, e_done, e_fault;
  logic [DEPTH-1:0][1:0]        e_kind;
  logic [DEPTH-1:0][AREG_W-1:0] e_dest;
  logic [DEPTH-1:0][DATA_W-1:0] e_value;
  logic [DEPTH-1:0][PC_W-1:0]   e_pc;

  logic [RETIRE_W-1:0] take;
  logic [CNT_W-1:0]    take_cnt;
  logic [DEPTH-1:0]    take_mask, kill_mask, drop_mask;
  logic                head_fault;

  // Ring occupancy and the allocation side.
  assign full        = (IDX_W'(rcb_pkg::ring_add(32'(tail_q), 32'd1, DEPTH)) == head_q);
  assign alloc_ready = !full;
  assign alloc_tag   = tail_q;
  assign alloc_fire  = alloc_valid && alloc_ready;

  // Completion and flush events.
  assign cmp_hit      = done_valid && e_valid[done_tag] && !e_done[done_tag];
  assign exc_flush    = head_fault;
  assign cmp_apply    = cmp_hit && !exc_flush;
  assign mis_flush    = cmp_apply && done_mispred;
  assign alloc_commit = alloc_fire && !exc_flush && !mis_flush;

  rcb_entry_store #(
    .DEPTH(DEPTH), .AREG_W(AREG_W), .DATA_W(DATA_W), .PC_W(PC_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .alloc_we(alloc_commit), .alloc_idx(tail_q), .alloc_kind(alloc_kind),
    .alloc_dest(alloc_dest), .alloc_pc(alloc_pc),
    .cmp_we(cmp_apply), .cmp_idx(done_tag), .cmp_value(done_value),
    .cmp_fault(done_fault), .drop_mask(drop_mask),
    .e_valid(e_valid), .e_done(e_done), .e_fault(e_fault), .e_kind(e_kind),
    .e_dest(e_dest), .e_value(e_value), .e_pc(e_pc)
  );

  rcb_retire_scan #(
    .DEPTH(DEPTH), .RETIRE_W(RETIRE_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_scan (
    .head(head_q), .e_valid(e_valid), .e_done(e_done), .e_fault(e_fault),
    .take(take), .take_cnt(take_cnt), .take_mask(take_mask), .head_fault(head_fault)
  );

  // Slots to discard: everything on an exception, younger than the branch
  // on a misprediction.
  always_comb begin
    int unsigned branch_age;
    branch_age = rcb_pkg::ring_age(32'(done_tag), 32'(head_q), DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      if (exc_flush)
        kill_mask[i] = e_valid[i];
      else if (mis_flush)
        kill_mask[i] = e_valid[i] &&
                       (rcb_pkg::ring_age(32'(i), 32'(head_q), DEPTH) > branch_age);
      else
        kill_mask[i] = 1'b0;
    end
  end

  assign drop_mask = take_mask | kill_mask;

  // Pointer update.
  assign head_d = IDX_W'(rcb_pkg::ring_add(32'(head_q), 32'(take_cnt), DEPTH));

  always_comb begin
    if (exc_flush)
      tail_d = head_q;
    else if (mis_flush)
      tail_d = IDX_W'(rcb_pkg::ring_add(32'(done_tag), 32'd1, DEPTH));
    else if (alloc_commit)
      tail_d = IDX_W'(rcb_pkg::ring_add(32'(tail_q), 32'd1, DEPTH));
    else
      tail_d = tail_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  // Commit lanes.
  for (genvar s = 0; s < RETIRE_W; s++) begin : g_lane
    logic [IDX_W-1:0] lane_idx;
    assign lane_idx = IDX_W'(rcb_pkg::ring_add(32'(head_q), s, DEPTH));
    assign ret_valid[s] = take[s];
    assign ret_we[s]    = take[s] && rcb_pkg::kind_writes_reg(e_kind[lane_idx]);
    assign ret_dest[s*AREG_W +: AREG_W] = take[s] ? e_dest[lane_idx]  : '0;
    assign ret_data[s*DATA_W +: DATA_W] = take[s] ? e_value[lane_idx] : '0;
  end

  // Redirect report, registered.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      redirect_cause <= 1'b0;
      redirect_pc    <= '0;
    end else begin
      redirect_valid <= exc_flush || mis_flush;
      redirect_cause <= mis_flush;
      if (exc_flush)
        redirect_pc <= e_pc[head_q];
      else if (mis_flush)
        redirect_pc <= done_target;
    end
  end

endmodule

// File: rtl/rcb_checks.sv
module rcb_checks #(
  parameter int DEPTH    = 16,
  parameter int RETIRE_W = 4,
  parameter int IDX_W    = $clog2(DEPTH)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [RETIRE_W-1:0] ret_valid,
  input logic                alloc_ready,
  input logic [IDX_W-1:0]    head_q,
  input logic [IDX_W-1:0]    tail_q,
  input logic                exc_flush,
  input logic                mis_flush,
  input logic [IDX_W-1:0]    done_tag,
  input logic                redirect_valid
);

  assert_retire_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (((ret_valid + RETIRE_W'(1)) & ret_valid) == '0));

  assert_empty_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (head_q == tail_q) |-> (ret_valid == '0));

  assert_refused_alloc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_ready && !exc_flush && !mis_flush) |=> (tail_q == $past(tail_q)));

  assert_fault_no_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_flush |-> (ret_valid == '0));

  assert_fault_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_flush |=> (head_q == tail_q));

  assert_branch_tail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mis_flush |=> (tail_q == IDX_W'((32'($past(done_tag)) + 32'd1) % DEPTH)));

  assert_redirect_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_flush || mis_flush) |=> redirect_valid);

  assert_redirect_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_flush || mis_flush) |=> !redirect_valid);

endmodule

bind reorder_commit_buffer rcb_checks #(
  .DEPTH(DEPTH), .RETIRE_W(RETIRE_W), .IDX_W(IDX_W)
) u_checks (
  .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .alloc_ready(alloc_ready),
  .head_q(head_q), .tail_q(tail_q), .exc_flush(exc_flush), .mis_flush(mis_flush),
  .done_tag(done_tag), .redirect_valid(redirect_valid)
);

// File: tb/reorder_commit_buffer_test.sv
`timescale 1ns/1ps
module reorder_commit_buffer_test;

  localparam int N  = 16;
  localparam int W  = 4;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam int PW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 1'b0;
  logic [1:0] alloc_kind = '0;
  logic [AW-1:0] alloc_dest = '0;
  logic [PW-1:0] alloc_pc = '0;
  logic alloc_ready;
  logic [3:0] alloc_tag;
  logic done_valid = 1'b0;
  logic [3:0] done_tag = '0;
  logic [DW-1:0] done_value = '0;
  logic done_fault = 1'b0;
  logic done_mispred = 1'b0;
  logic [PW-1:0] done_target = '0;
  logic [W-1:0] ret_valid, ret_we;
  logic [W*AW-1:0] ret_dest;
  logic [W*DW-1:0] ret_data;
  logic redirect_valid, redirect_cause;
  logic [PW-1:0] redirect_pc;

  always #5 clk = ~clk;

  reorder_commit_buffer uut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_dest(alloc_dest),
    .alloc_pc(alloc_pc), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .done_valid(done_valid), .done_tag(done_tag), .done_value(done_value),
    .done_fault(done_fault), .done_mispred(done_mispred), .done_target(done_target),
    .ret_valid(ret_valid), .ret_we(ret_we), .ret_dest(ret_dest), .ret_data(ret_data),
    .redirect_valid(redirect_valid), .redirect_cause(redirect_cause),
    .redirect_pc(redirect_pc)
  );

  int nchk = 0;
  int nfail = 0;

  // Bench ring model.
  bit          m_valid [N];
  bit          m_done  [N];
  bit          m_fault [N];
  logic [1:0]  m_kind  [N];
  logic [AW-1:0] m_dest [N];
  logic [DW-1:0] m_value [N];
  logic [PW-1:0] m_pc   [N];
  int          m_head, m_tail;
  bit          m_rv, m_rcause;
  logic [PW-1:0] m_rpc;

  function automatic int wrap(int x);
    return ((x % N) + N) % N;
  endfunction

  function automatic int age(int idx);
    return wrap(idx - m_head);
  endfunction

  function automatic bit writes(logic [1:0] k);
    return (k == 2'd0) || (k == 2'd3);
  endfunction

  function automatic bit model_full();
    return wrap(m_tail + 1) == m_head;
  endfunction

  function automatic int model_cnt();
    int c = 0;
    for (int s = 0; s < W; s++) begin
      int ix = wrap(m_head + s);
      if (m_valid[ix] && m_done[ix] && !m_fault[ix]) c++;
      else break;
    end
    return c;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_done[i] = 0; m_fault[i] = 0;
      m_kind[i] = '0; m_dest[i] = '0; m_value[i] = '0; m_pc[i] = '0;
    end
    m_head = 0; m_tail = 0; m_rv = 0; m_rcause = 0; m_rpc = '0;
  endtask

  task automatic compare_all();
    int cnt = model_cnt();
    chk("R3", alloc_ready, !model_full());
    chk("R2", alloc_tag, m_tail);
    for (int s = 0; s < W; s++) begin
      int ix = wrap(m_head + s);
      bit t = (s < cnt);
      chk("R5", ret_valid[s], t);
      chk("R6", ret_we[s], t && writes(m_kind[ix]));
      chk("R6", ret_dest[s*AW +: AW], t ? m_dest[ix] : '0);
      chk("R4", ret_data[s*DW +: DW], t ? m_value[ix] : '0);
    end
    chk("R11", redirect_valid, m_rv);
    if (m_rv) begin
      chk(m_rcause ? "R8" : "R7", redirect_pc, m_rpc);
      chk(m_rcause ? "R8" : "R7", redirect_cause, m_rcause);
    end
  endtask

  // Advance the model by one clock using the inputs held across the edge.
  task automatic model_update();
    int cnt = model_cnt();
    int oh = m_head;
    bit exc = m_valid[oh] && m_done[oh] && m_fault[oh];
    bit fire = alloc_valid && !model_full();
    int k = int'(done_tag);
    bit hit = done_valid && m_valid[k] && !m_done[k];
    bit apply = hit && !exc;
    bit mis = apply && done_mispred;
    int kage = age(k);
    bit kill [N];
    logic [PW-1:0] fault_pc = m_pc[oh];
    for (int i = 0; i < N; i++)
      kill[i] = exc ? m_valid[i] : (mis && m_valid[i] && age(i) > kage);
    for (int s = 0; s < cnt; s++) begin
      int ix = wrap(oh + s);
      m_valid[ix] = 0; m_done[ix] = 0; m_fault[ix] = 0;
    end
    for (int i = 0; i < N; i++)
      if (kill[i]) begin m_valid[i] = 0; m_done[i] = 0; m_fault[i] = 0; end
    if (apply) begin
      m_done[k] = 1; m_fault[k] = done_fault; m_value[k] = done_value;
    end
    if (fire && !exc && !mis) begin
      m_valid[m_tail] = 1; m_done[m_tail] = 0; m_fault[m_tail] = 0;
      m_kind[m_tail] = alloc_kind; m_dest[m_tail] = alloc_dest;
      m_pc[m_tail] = alloc_pc; m_value[m_tail] = '0;
    end
    if (exc) m_tail = oh;
    else if (mis) m_tail = wrap(k + 1);
    else if (fire) m_tail = wrap(m_tail + 1);
    m_head = wrap(oh + cnt);
    m_rv = exc || mis;
    m_rcause = mis;
    if (exc) m_rpc = fault_pc;
    else if (mis) m_rpc = done_target;
  endtask

  task automatic cycle();
    #1 compare_all();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    alloc_valid = 0; done_valid = 0; done_fault = 0; done_mispred = 0;
  endtask

  task automatic put_alloc(logic [1:0] k, logic [AW-1:0] d, logic [PW-1:0] pc);
    alloc_valid = 1; alloc_kind = k; alloc_dest = d; alloc_pc = pc;
  endtask

  task automatic put_done(int tag, logic [DW-1:0] v, bit f, bit mp, logic [PW-1:0] tgt);
    done_valid = 1; done_tag = 4'(tag); done_value = v;
    done_fault = f; done_mispred = mp; done_target = tgt;
  endtask

  task automatic drain();
    for (int guard = 0; guard < 64 && m_head != m_tail; guard++) begin
      idle_inputs();
      for (int s = 0; s < N; s++) begin
        int ix = wrap(m_head + s);
        if (m_valid[ix] && !m_done[ix]) begin
          put_done(ix, $urandom, 0, 0, '0);
          break;
        end
      end
      cycle();
    end
    idle_inputs();
    cycle();
  endtask

  initial begin
    #1_000_000;
    nfail++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int base;
    int k_tag;
    void'($urandom(32'd48611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state seen at the ports
    #1;
    chk("R1", alloc_ready, 1);
    chk("R1", alloc_tag, 0);
    chk("R1", ret_valid, 0);
    chk("R1", redirect_valid, 0);
    rst_n = 1;
    @(negedge clk);

    // R2, R3: fill the ring, then one refused request
    for (int i = 0; i < 16; i++) begin
      put_alloc(2'(i % 4), 5'(i + 1), 32'h1000 + 32'(4 * i));
      cycle();
    end
    idle_inputs();
    #1 chk("R3", alloc_ready, 0);
    chk("R3", alloc_tag, 15);

    // R4, R5: out-of-order completion, results held until the head is ready
    for (int i = 1; i <= 5; i++) begin
      put_done(i, 32'hA000 + 32'(i), 0, 0, '0);
      cycle();
      chk("R4", ret_valid, 0);
    end
    put_done(0, 32'hA000, 0, 0, '0);
    cycle();
    idle_inputs();
    #1 chk("R5", ret_valid, 4'hF);
    chk("R4", ret_data[DW +: DW], 32'hA001);
    chk("R6", ret_we, 4'b1001);
    cycle();
    chk("R5", ret_valid, 4'h3);
    // R9: completing an already finished slot leaves its result unchanged
    put_done(5, 32'hBAD0, 0, 0, '0);
    cycle();
    drain();

    // R9: completion to an empty slot is ignored
    put_done(wrap(m_tail + 2), 32'hDEAD, 0, 0, '0);
    cycle();
    idle_inputs();
    repeat (3) begin
      put_alloc(2'd0, 5'd7, 32'h2000);
      cycle();
    end
    idle_inputs();
    cycle();
    chk("R9", ret_valid, 0);
    drain();

    // R7, R10: fault reaches the head while a completion and an allocation arrive
    base = m_tail;
    for (int i = 0; i < 3; i++) begin
      put_alloc(2'd3, 5'(10 + i), 32'h3000 + 32'(4 * i));
      cycle();
    end
    idle_inputs();
    put_done(base, 32'h11, 0, 0, '0);
    cycle();
    put_done(wrap(base + 1), 32'h22, 1, 0, '0);
    cycle();
    put_done(wrap(base + 2), 32'h33, 0, 0, '0);
    put_alloc(2'd0, 5'd3, 32'h3100);
    cycle();
    idle_inputs();
    #1 chk("R7", redirect_valid, 1);
    chk("R7", redirect_pc, 32'h3004);
    chk("R10", alloc_tag, wrap(base + 1));
    chk("R7", ret_valid, 0);
    cycle();
    chk("R11", redirect_valid, 0);

    // R8: mispredicted branch in the middle of six slots
    base = m_tail;
    for (int i = 0; i < 6; i++) begin
      put_alloc(i == 2 ? 2'd1 : 2'd0, 5'(20 + i), 32'h5000 + 32'(4 * i));
      cycle();
    end
    idle_inputs();
    put_done(wrap(base + 4), 32'h44, 0, 0, '0);
    cycle();
    k_tag = wrap(base + 2);
    put_done(k_tag, 32'h0, 0, 1, 32'h7770);
    cycle();
    idle_inputs();
    #1 chk("R8", alloc_tag, wrap(k_tag + 1));
    chk("R8", redirect_pc, 32'h7770);
    chk("R8", redirect_cause, 1);
    put_done(base, 32'h55, 0, 0, '0);
    cycle();
    put_done(wrap(base + 1), 32'h66, 0, 0, '0);
    cycle();
    idle_inputs();
    #1 chk("R8", ret_valid, 4'h3);
    chk("R6", ret_we, 4'h1);
    cycle();
    drain();

    // Random mix of allocation, completion, faults and mispredicts.
    for (int c = 0; c < 3000; c++) begin
      idle_inputs();
      if ($urandom_range(0, 1) == 1)
        put_alloc(2'($urandom), 5'($urandom), $urandom);
      if ($urandom_range(0, 2) != 0) begin
        int pick = $urandom_range(0, N - 1);
        put_done(pick, $urandom, $urandom_range(0, 39) == 0,
                 $urandom_range(0, 29) == 0, $urandom);
      end
      cycle();
    end
    idle_inputs();
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule